// File: doc/BRIEF.md
# Battery Protection Fault Qualifier

This block watches cell-voltage conversion results and a discharge current-sense magnitude. It compares each against a programmable trip level and raises a fault only once the condition has lasted for a programmable qualification time. There are four fault channels. Overvoltage and undervoltage come from the 14-bit cell code. Short-circuit and overcurrent in discharge come from the current-sense value, given in millivolts. Each channel emits a one-cycle pulse that a downstream status register can latch.

The voltage trip levels are rebuilt from an 8-bit field placed between fixed upper and lower bits. The current trip levels come from two millivolt tables, and a range bit selects the higher set. Each channel has its own delay table, and all delays are counted in periods of a shared timebase strobe. The duration of that strobe is set by two parameters: strobes per second and strobes per millisecond. The short-circuit delays are counted in strobes of 10 µs each. A test bit removes every delay. When conversions are disabled, both voltage channels go quiet.

Top module: `prot_qual_top`

## Requirements
- R1: The overvoltage level is the 14-bit value {2'b10, ov_trip_i, 4'b1000}. The overvoltage condition holds when the sampled code is greater than or equal to that level.
- R2: The undervoltage level is the 14-bit value {2'b01, uv_trip_i, 4'b0000}. The undervoltage condition holds when the sampled code is less than or equal to that level.
- R3: The cell code is sampled only on a clock edge where vcode_vld_i is 1 and adc_en_i is 1. Between strobes the last comparison result is held, and code changes without a strobe have no effect.
- R4: While adc_en_i is 0, both voltage conditions are cleared and strobes are ignored, so no OV or UV pulse can occur. The current channels keep working.
- R5: The short-circuit level in mV for scd_thr_i codes 0..7 is 22,33,44,56,67,78,89,100 when hi_range_i is 0, and 44,67,89,111,133,155,178,200 when it is 1. The condition holds when isense_i is at or above the level.
- R6: The overcurrent level in mV for ocd_thr_i codes 0..15 is 8,11,14,17,19,22,25,28,31,33,36,39,42,44,47,50 at low range. At high range it is 17,22,28,33,39,44,50,56,61,67,72,78,83,89,94,100. The condition holds at or above the level.
- R7: The OV delay in strobes is S_TICKS times 1,2,4,8 for ov_dly_i 0..3. The UV delay is S_TICKS times 1,4,8,16 for uv_dly_i 0..3. A voltage pulse is visible one cycle after the edge that samples the L-th strobe, and strobes count from the edge after the sampling strobe.
- R8: The OCD delay is MS_TICKS times 8,20,40,80,160,320,640,1280 for ocd_dly_i 0..7. The SCD delay is 7,10,20,40 strobes for scd_dly_i 0..3. Current conditions count strobes from the edge where the input is present.
- R9: When dly_bypass_i is 1, a channel fires at the first edge that sees its condition, whether or not a strobe is present.
- R10: If a condition drops before its delay expires, its count returns to zero and the next event needs the full delay.
- R11: Each qualified event produces exactly one pulse of one cycle. The channel must see its condition drop before it can fire again. All pulses are 0 after reset.
- R12: The delay counters advance only on edges where tick_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vcode_i | input | 14 | Cell voltage conversion code |
| vcode_vld_i | input | 1 | Strobe marking a new cell code |
| isense_i | input | CS_W | Discharge sense magnitude in mV |
| ov_trip_i | input | 8 | Overvoltage level middle bits |
| uv_trip_i | input | 8 | Undervoltage level middle bits |
| ov_dly_i | input | 2 | Overvoltage delay code |
| uv_dly_i | input | 2 | Undervoltage delay code |
| scd_thr_i | input | 3 | Short-circuit level code |
| scd_dly_i | input | 2 | Short-circuit delay code |
| ocd_thr_i | input | 4 | Overcurrent level code |
| ocd_dly_i | input | 3 | Overcurrent delay code |
| hi_range_i | input | 1 | Selects the doubled current level tables |
| adc_en_i | input | 1 | Conversions enabled; gates voltage channels |
| dly_bypass_i | input | 1 | Removes all qualification delays |
| tick_i | input | 1 | Timebase strobe |
| ov_pulse_o | output | 1 | Overvoltage fault pulse |
| uv_pulse_o | output | 1 | Undervoltage fault pulse |
| scd_pulse_o | output | 1 | Short-circuit fault pulse |
| ocd_pulse_o | output | 1 | Overcurrent fault pulse |

## Verification
The hardest cases to reach are the ones where the delay stops one strobe short. One is a condition that drops a single strobe before expiry. Another is a conversion disable arriving while an overvoltage count is half done. Neither shows at the outputs unless the count is timed exactly. The bench shrinks the strobe scale through parameters and holds the strobe high every cycle, so each delay is an exact cycle count. It removes a condition one cycle before the expected pulse, or turns conversions off mid-count, and then confirms that the pulse is missing. After that it reapplies the condition and confirms that the full delay is needed again.

// File: rtl/prot_pkg.sv
package prot_pkg;
    localparam int CH_OV  = 0;
    localparam int CH_UV  = 1;
    localparam int CH_SCD = 2;
    localparam int CH_OCD = 3;
    localparam int NUM_CH = 4;
    localparam int VCODE_W = 14;

    // short-circuit trip level in mV
    function automatic logic [7:0] scd_level(input logic [2:0] code, input logic hi);
        logic [7:0] lo_mv, hi_mv;
        case (code)
            3'd0: begin lo_mv = 8'd22;  hi_mv = 8'd44;  end
            3'd1: begin lo_mv = 8'd33;  hi_mv = 8'd67;  end
            3'd2: begin lo_mv = 8'd44;  hi_mv = 8'd89;  end
            3'd3: begin lo_mv = 8'd56;  hi_mv = 8'd111; end
            3'd4: begin lo_mv = 8'd67;  hi_mv = 8'd133; end
            3'd5: begin lo_mv = 8'd78;  hi_mv = 8'd155; end
            3'd6: begin lo_mv = 8'd89;  hi_mv = 8'd178; end
            default: begin lo_mv = 8'd100; hi_mv = 8'd200; end
        endcase
        return hi ? hi_mv : lo_mv;
    endfunction

    // overcurrent trip level in mV
    function automatic logic [7:0] ocd_level(input logic [3:0] code, input logic hi);
        logic [7:0] lo_mv, hi_mv;
        case (code)
            4'd0:  begin lo_mv = 8'd8;  hi_mv = 8'd17;  end
            4'd1:  begin lo_mv = 8'd11; hi_mv = 8'd22;  end
            4'd2:  begin lo_mv = 8'd14; hi_mv = 8'd28;  end
            4'd3:  begin lo_mv = 8'd17; hi_mv = 8'd33;  end
            4'd4:  begin lo_mv = 8'd19; hi_mv = 8'd39;  end
            4'd5:  begin lo_mv = 8'd22; hi_mv = 8'd44;  end
            4'd6:  begin lo_mv = 8'd25; hi_mv = 8'd50;  end
            4'd7:  begin lo_mv = 8'd28; hi_mv = 8'd56;  end
            4'd8:  begin lo_mv = 8'd31; hi_mv = 8'd61;  end
            4'd9:  begin lo_mv = 8'd33; hi_mv = 8'd67;  end
            4'd10: begin lo_mv = 8'd36; hi_mv = 8'd72;  end
            4'd11: begin lo_mv = 8'd39; hi_mv = 8'd78;  end
            4'd12: begin lo_mv = 8'd42; hi_mv = 8'd83;  end
            4'd13: begin lo_mv = 8'd44; hi_mv = 8'd89;  end
            4'd14: begin lo_mv = 8'd47; hi_mv = 8'd94;  end
            default: begin lo_mv = 8'd50; hi_mv = 8'd100; end
        endcase
        return hi ? hi_mv : lo_mv;
    endfunction

    function automatic int unsigned ov_mult(input logic [1:0] code);
        return 32'd1 << code;
    endfunction

    function automatic int unsigned uv_mult(input logic [1:0] code);
        case (code)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 16;
        endcase
    endfunction

    function automatic int unsigned ocd_ms(input logic [2:0] code);
        case (code)
            3'd0: return 8;
            3'd1: return 20;
            3'd2: return 40;
            3'd3: return 80;
            3'd4: return 160;
            3'd5: return 320;
            3'd6: return 640;
            default: return 1280;
        endcase
    endfunction

    // short-circuit delay in 10 us strobes
    function automatic int unsigned scd_steps(input logic [1:0] code);
        case (code)
            2'd0: return 7;
            2'd1: return 10;
            2'd2: return 20;
            default: return 40;
        endcase
    endfunction
endpackage

// File: rtl/prot_vcmp.sv
module prot_vcmp
    import prot_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [VCODE_W-1:0] code_i,
    input  logic               vld_i,
    input  logic               adc_en_i,
    input  logic [7:0]         ov_field_i,
    input  logic [7:0]         uv_field_i,
    output logic               ov_cond_o,
    output logic               uv_cond_o
);
    typedef struct packed {
        logic ov;
        logic uv;
    } vst_t;

    vst_t st_d, st_q;
    logic [VCODE_W-1:0] ov_level, uv_level;

    always_comb begin
        ov_level = {2'b10, ov_field_i, 4'b1000};
        uv_level = {2'b01, uv_field_i, 4'b0000};
        st_d = st_q;
        if (!adc_en_i) begin
            st_d = '0;
        end else if (vld_i) begin
            st_d.ov = (code_i >= ov_level);
            st_d.uv = (code_i <= uv_level);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ov_cond_o = st_q.ov;
    assign uv_cond_o = st_q.uv;

    // R3: no strobe, no change
    p_hold_between_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!vld_i && adc_en_i) |=> ($stable(ov_cond_o) && $stable(uv_cond_o)));
    // R4: disabled conversions clear both conditions
    p_adc_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !adc_en_i |=> (!ov_cond_o && !uv_cond_o));
endmodule

// File: rtl/prot_cur_thr.sv
module prot_cur_thr
    import prot_pkg::*;
#(
    parameter bit SHORT = 1'b0
) (
    input  logic [3:0] code_i,
    input  logic       hi_range_i,
    output logic [7:0] mv_o
);
    generate
        if (SHORT) begin : g_scd
            assign mv_o = scd_level(code_i[2:0], hi_range_i);
        end else begin : g_ocd
            assign mv_o = ocd_level(code_i, hi_range_i);
        end
    endgenerate
endmodule

// File: rtl/prot_dly_qual.sv
module prot_dly_qual #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cond_i,
    input  logic             tick_i,
    input  logic             bypass_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             pulse_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             pulse;
    } qst_t;

    qst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pulse = 1'b0;
        if (!cond_i) begin
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (!st_q.done) begin
            if (bypass_i) begin
                st_d.done  = 1'b1;
                st_d.pulse = 1'b1;
                st_d.cnt   = '0;
            end else if (tick_i) begin
                if (st_q.cnt + CNT_W'(1) >= lim_i) begin
                    st_d.done  = 1'b1;
                    st_d.pulse = 1'b1;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;

    // R11: pulses last one cycle
    p_one_cycle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |=> !pulse_o);
    // R10: a pulse follows a present condition
    p_cond_behind_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |-> $past(cond_i));
    // R10: a dropped condition restarts the count
    p_drop_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cond_i |=> (st_q.cnt == '0 && !pulse_o));
    // R12: counters stand still without a strobe
    p_tick_gate_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i && !tick_i && !bypass_i) |=> (!pulse_o && $stable(st_q.cnt)));
    // R9: bypass fires on the first edge
    p_bypass_fast_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i && bypass_i && !st_q.done) |=> pulse_o);
endmodule

// File: rtl/prot_qual_top.sv
module prot_qual_top
    import prot_pkg::*;
#(
    parameter int unsigned S_TICKS  = 100000,
    parameter int unsigned MS_TICKS = 100,
    parameter int unsigned CS_W     = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [13:0]        vcode_i,
    input  logic               vcode_vld_i,
    input  logic [CS_W-1:0]    isense_i,
    input  logic [7:0]         ov_trip_i,
    input  logic [7:0]         uv_trip_i,
    input  logic [1:0]         ov_dly_i,
    input  logic [1:0]         uv_dly_i,
    input  logic [2:0]         scd_thr_i,
    input  logic [1:0]         scd_dly_i,
    input  logic [3:0]         ocd_thr_i,
    input  logic [2:0]         ocd_dly_i,
    input  logic               hi_range_i,
    input  logic               adc_en_i,
    input  logic               dly_bypass_i,
    input  logic               tick_i,
    output logic               ov_pulse_o,
    output logic               uv_pulse_o,
    output logic               scd_pulse_o,
    output logic               ocd_pulse_o
);
    localparam int unsigned MAX_LIM = 16 * S_TICKS + 1280 * MS_TICKS + 40;
    localparam int unsigned CNT_W   = $clog2(MAX_LIM + 1);

    logic [7:0] scd_mv, ocd_mv;
    logic [NUM_CH-1:0]            cond;
    logic [NUM_CH-1:0]            pulse;
    logic [NUM_CH-1:0][CNT_W-1:0] lim;

    prot_vcmp u_vcmp (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .code_i     (vcode_i),
        .vld_i      (vcode_vld_i),
        .adc_en_i   (adc_en_i),
        .ov_field_i (ov_trip_i),
        .uv_field_i (uv_trip_i),
        .ov_cond_o  (cond[CH_OV]),
        .uv_cond_o  (cond[CH_UV])
    );

    prot_cur_thr #(.SHORT(1'b1)) u_scd_thr (
        .code_i     ({1'b0, scd_thr_i}),
        .hi_range_i (hi_range_i),
        .mv_o       (scd_mv)
    );

    prot_cur_thr #(.SHORT(1'b0)) u_ocd_thr (
        .code_i     (ocd_thr_i),
        .hi_range_i (hi_range_i),
        .mv_o       (ocd_mv)
    );

    always_comb begin
        cond[CH_SCD] = (isense_i >= CS_W'(scd_mv));
        cond[CH_OCD] = (isense_i >= CS_W'(ocd_mv));
        lim[CH_OV]   = CNT_W'(S_TICKS * ov_mult(ov_dly_i));
        lim[CH_UV]   = CNT_W'(S_TICKS * uv_mult(uv_dly_i));
        lim[CH_SCD]  = CNT_W'(scd_steps(scd_dly_i));
        lim[CH_OCD]  = CNT_W'(MS_TICKS * ocd_ms(ocd_dly_i));
    end

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_qual
            prot_dly_qual #(.CNT_W(CNT_W)) u_qual (
                .clk_i    (clk_i),
                .rst_ni   (rst_ni),
                .cond_i   (cond[ch]),
                .tick_i   (tick_i),
                .bypass_i (dly_bypass_i),
                .lim_i    (lim[ch]),
                .pulse_o  (pulse[ch])
            );
        end
    endgenerate

    assign ov_pulse_o  = pulse[CH_OV];
    assign uv_pulse_o  = pulse[CH_UV];
    assign scd_pulse_o = pulse[CH_SCD];
    assign ocd_pulse_o = pulse[CH_OCD];

    // R4: two cycles of disabled conversions silence the voltage faults
    p_adc_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!adc_en_i && !$past(adc_en_i) && !$past(adc_en_i, 2)) |-> (!ov_pulse_o && !uv_pulse_o));
endmodule

// File: tb/prot_qual_top_tb_top.sv
module prot_qual_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [13:0] vcode = 14'h2000;
    logic vld = 1'b0;
    logic [7:0] isense = 8'd0;
    logic [7:0] ov_trip = 8'hFF, uv_trip = 8'h00;
    logic [1:0] ov_dly = 2'd0, uv_dly = 2'd0, scd_dly = 2'd0;
    logic [2:0] scd_thr = 3'd0, ocd_dly = 3'd0;
    logic [3:0] ocd_thr = 4'd0;
    logic hi_rng = 1'b0, adc_en = 1'b1, bypass = 1'b0, tick = 1'b1;
    logic ov_p, uv_p, scd_p, ocd_p;
    logic [3:0] pv;
    assign pv = {ocd_p, scd_p, uv_p, ov_p};

    prot_qual_top #(.S_TICKS(3), .MS_TICKS(1), .CS_W(8)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .vcode_i(vcode), .vcode_vld_i(vld),
        .isense_i(isense), .ov_trip_i(ov_trip), .uv_trip_i(uv_trip),
        .ov_dly_i(ov_dly), .uv_dly_i(uv_dly), .scd_thr_i(scd_thr), .scd_dly_i(scd_dly),
        .ocd_thr_i(ocd_thr), .ocd_dly_i(ocd_dly), .hi_range_i(hi_rng), .adc_en_i(adc_en),
        .dly_bypass_i(bypass), .tick_i(tick), .ov_pulse_o(ov_p), .uv_pulse_o(uv_p),
        .scd_pulse_o(scd_p), .ocd_pulse_o(ocd_p)
    );

    int pcnt [4] = '{0, 0, 0, 0};
    int base [4];
    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        for (int i = 0; i < 4; i++) if (pv[i]) pcnt[i] <= pcnt[i] + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic snap();
        for (int i = 0; i < 4; i++) base[i] = pcnt[i];
    endtask

    task automatic neutral();
        isense = 8'd0; vcode = 14'h2000; vld = 1'b1;
        @(negedge clk); vld = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // latency in negedges from the drive point to the visible pulse
    task automatic lat(input int ch, input bit volt, input logic [13:0] code,
                       input logic [7:0] cur, input int exp, input string req);
        int got = -1;
        if (volt) begin vcode = code; vld = 1'b1; end
        else isense = cur;
        for (int n = 1; n <= exp + 20; n++) begin
            @(negedge clk);
            if (n == 1) vld = 1'b0;
            if (pv[ch]) begin got = n; break; end
        end
        check(req, got, exp);
        neutral();
    endtask

    // {chan[1:0], value[13:0], field[7:0], range, expected}
    localparam logic [25:0] VEC [20] = '{
        {2'd0, 14'h2AC8, 8'hAC, 1'b0, 1'b1}, {2'd0, 14'h2AC7, 8'hAC, 1'b0, 1'b0},
        {2'd0, 14'h2008, 8'h00, 1'b0, 1'b1}, {2'd0, 14'h2007, 8'h00, 1'b0, 1'b0},
        {2'd1, 14'h1970, 8'h97, 1'b0, 1'b1}, {2'd1, 14'h1971, 8'h97, 1'b0, 1'b0},
        {2'd1, 14'h1FF0, 8'hFF, 1'b0, 1'b1}, {2'd1, 14'h1FF1, 8'hFF, 1'b0, 1'b0},
        {2'd2, 14'd22,  8'd0, 1'b0, 1'b1}, {2'd2, 14'd21,  8'd0, 1'b0, 1'b0},
        {2'd2, 14'd43,  8'd0, 1'b1, 1'b0}, {2'd2, 14'd44,  8'd0, 1'b1, 1'b1},
        {2'd2, 14'd199, 8'd7, 1'b1, 1'b0}, {2'd2, 14'd200, 8'd7, 1'b1, 1'b1},
        {2'd3, 14'd8,   8'd0, 1'b0, 1'b1}, {2'd3, 14'd7,   8'd0, 1'b0, 1'b0},
        {2'd3, 14'd99,  8'd15, 1'b1, 1'b0}, {2'd3, 14'd100, 8'd15, 1'b1, 1'b1},
        {2'd3, 14'd22,  8'd5, 1'b0, 1'b1}, {2'd3, 14'd43,  8'd5, 1'b1, 1'b0}
    };

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset pulses", int'(pv), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // threshold table walk, delays bypassed
        bypass = 1'b1;
        for (int v = 0; v < 20; v++) begin
            logic [1:0] ch;
            ch = VEC[v][25:24];
            snap();
            hi_rng = VEC[v][1];
            case (ch)
                2'd0: begin ov_trip = VEC[v][9:2]; vcode = VEC[v][23:10]; vld = 1'b1; end
                2'd1: begin uv_trip = VEC[v][9:2]; vcode = VEC[v][23:10]; vld = 1'b1; end
                2'd2: begin scd_thr = VEC[v][4:2]; isense = VEC[v][17:10]; end
                default: begin ocd_thr = VEC[v][5:2]; isense = VEC[v][17:10]; end
            endcase
            @(negedge clk); vld = 1'b0;
            repeat (5) @(negedge clk);
            case (ch)
                2'd0: check("R1 OV level compare", pcnt[0] - base[0], int'(VEC[v][0]));
                2'd1: check("R2 UV level compare", pcnt[1] - base[1], int'(VEC[v][0]));
                2'd2: check("R5 SCD level table", pcnt[2] - base[2], int'(VEC[v][0]));
                default: check("R6 OCD level table", pcnt[3] - base[3], int'(VEC[v][0]));
            endcase
            neutral();
            ov_trip = 8'hFF; uv_trip = 8'h00; hi_rng = 1'b0;
        end

        // R9: bypass latency
        ov_trip = 8'h00;
        lat(0, 1'b1, 14'h3000, 8'd0, 2, "R9 OV bypass latency");
        scd_thr = 3'd0;
        lat(2, 1'b0, 14'h0, 8'd30, 1, "R9 SCD bypass latency");
        bypass = 1'b0;

        // R7: voltage delay tables (S_TICKS=3, strobe every cycle)
        for (int c = 0; c < 4; c++) begin
            ov_dly = 2'(c);
            lat(0, 1'b1, 14'h3000, 8'd0, 3 * (1 << c) + 1, "R7 OV delay");
        end
        ov_trip = 8'hFF; uv_trip = 8'h80;
        for (int c = 0; c < 4; c++) begin
            int m;
            m = (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 16;
            uv_dly = 2'(c);
            lat(1, 1'b1, 14'h1000, 8'd0, 3 * m + 1, "R7 UV delay");
        end
        uv_trip = 8'h00;

        // R8: current delay tables
        scd_thr = 3'd0; ocd_thr = 4'd15;
        scd_dly = 2'd0; lat(2, 1'b0, 14'h0, 8'd30, 7, "R8 SCD delay code 0");
        scd_dly = 2'd1; lat(2, 1'b0, 14'h0, 8'd30, 10, "R8 SCD delay code 1");
        scd_dly = 2'd2; lat(2, 1'b0, 14'h0, 8'd30, 20, "R8 SCD delay code 2");
        scd_dly = 2'd3; lat(2, 1'b0, 14'h0, 8'd30, 40, "R8 SCD delay code 3");
        scd_thr = 3'd7; ocd_thr = 4'd0;
        ocd_dly = 3'd0; lat(3, 1'b0, 14'h0, 8'd20, 8, "R8 OCD delay code 0");
        ocd_dly = 3'd3; lat(3, 1'b0, 14'h0, 8'd20, 80, "R8 OCD delay code 3");
        ocd_dly = 3'd7; lat(3, 1'b0, 14'h0, 8'd20, 1280, "R8 OCD delay code 7");

        // R10: drop one strobe before expiry, then full delay again
        scd_thr = 3'd0; scd_dly = 2'd3; ocd_thr = 4'd15;
        snap();
        isense = 8'd30;
        repeat (39) @(negedge clk);
        isense = 8'd0;
        repeat (2) @(negedge clk);
        check("R10 early drop gives no pulse", pcnt[2] - base[2], 0);
        lat(2, 1'b0, 14'h0, 8'd30, 40, "R10 full delay after restart");

        // R11: one pulse per event, re-arm after drop
        scd_dly = 2'd0;
        snap();
        isense = 8'd30;
        repeat (40) @(negedge clk);
        check("R11 single pulse while held", pcnt[2] - base[2], 1);
        isense = 8'd0; @(negedge clk);
        isense = 8'd30;
        repeat (20) @(negedge clk);
        check("R11 re-arm after drop", pcnt[2] - base[2], 2);
        isense = 8'd0; repeat (2) @(negedge clk);

        // R12: no strobe, no progress
        tick = 1'b0;
        snap();
        isense = 8'd30;
        repeat (30) @(negedge clk);
        check("R12 held without strobe", pcnt[2] - base[2], 0);
        tick = 1'b1;
        repeat (10) @(negedge clk);
        check("R12 fires once strobes resume", pcnt[2] - base[2], 1);
        isense = 8'd0; repeat (2) @(negedge clk);

        // R3: code without strobe ignored; result held between strobes
        ov_trip = 8'h00; bypass = 1'b1;
        snap();
        vcode = 14'h3FFF;
        repeat (5) @(negedge clk);
        check("R3 code without strobe ignored", pcnt[0] - base[0], 0);
        bypass = 1'b0; ov_dly = 2'd0;
        begin
            int got = -1;
            vcode = 14'h3000; vld = 1'b1;
            for (int n = 1; n <= 20; n++) begin
                @(negedge clk);
                if (n == 1) begin vld = 1'b0; vcode = 14'h2000; end
                if (ov_p) begin got = n; break; end
            end
            check("R3 result held between strobes", got, 4);
        end
        neutral();

        // R4: conversions disabled
        bypass = 1'b1; adc_en = 1'b0; scd_thr = 3'd0;
        repeat (2) @(negedge clk);
        snap();
        vcode = 14'h3FFF; vld = 1'b1; isense = 8'd30;
        @(negedge clk); vld = 1'b0;
        repeat (5) @(negedge clk);
        check("R4 OV silent when disabled", pcnt[0] - base[0], 0);
        check("R4 SCD unaffected", pcnt[2] - base[2], 1);
        isense = 8'd0;
        adc_en = 1'b1; bypass = 1'b0; ov_dly = 2'd3;
        snap();
        vcode = 14'h3000; vld = 1'b1;
        @(negedge clk); vld = 1'b0;
        repeat (10) @(negedge clk);
        adc_en = 1'b0;
        repeat (30) @(negedge clk);
        check("R4 disable mid-delay cancels OV", pcnt[0] - base[0], 0);
        adc_en = 1'b1;
        neutral();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule